// File: doc/BRIEF.md
# Bit-Serial CORDIC Sine Engine

This block computes the sine of an angle in the first quadrant using rotation-mode CORDIC, one bit per clock. The three working quantities (the two vector coordinates and the residual angle) are each kept in a 16-entry, 1-bit-wide memory. Every memory has a read/write port and a read-only port.

Each coordinate owns a single-bit add/subtract cell with a carry register. The cell is driven by a two-bit opcode. During an iteration, the read-only port fetches the shifted partner operand at an offset address. Past the top bit, that read repeats the sign bit, so the shifted operand is sign-extended.

A controller accepts an angle when the enable strobe is high and the engine is idle. It then loads the start values serially, runs sixteen iterations of one carry-clear cycle followed by sixteen bit cycles, and captures the final y word as the result.

Top module: `cordic_sine_seq`

## Requirements
- R1: After reset, `valid` is 0 and `value` is 0.
- R2: `theta` is unsigned, with angle = theta * (pi/2) / 65536. `value` is two's complement with 14 fraction bits, equal to round(sin(angle) * 16384) within 40 LSB.
- R3: A rising clock edge with `enable` high while the engine is idle accepts `theta`, and `valid` is 0 after that edge.
- R4: `valid` goes from 0 to 1 exactly 288 rising edges after the accepting edge. This is 16 load cycles plus 16 iterations of 17 cycles each.
- R5: While a computation runs, `valid` stays 0, and any `enable` pulse or change on `theta` is ignored. The result is that of the accepted angle.
- R6: Once `valid` is 1, it stays 1 and `value` stays constant for as long as `enable` is low, whatever `theta` does.
- R7: Cell opcodes are: 11 add, 10 subtract, 01 clear carry, 00 hold. With a cleared carry, a subtract forms the two's complement difference. In each iteration the x and y cells take opposite add/subtract operations, chosen from the sign of the residual angle; the angle cell takes the same operation as x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| enable | input | 1 | High marks a new angle on `theta` |
| theta | input | 16 | Angle, full scale is pi/2 |
| valid | output | 1 | High while `value` holds a finished result |
| value | output | 16 | Sine of the accepted angle, signed, 14 fraction bits |

## Verification
A wrong carry seed, a wrong shift address or a wrong direction bit corrupts every later iteration. Because the operands are serial, such a fault shows up only in `value`, once `valid` rises 288 cycles after acceptance, as an error far beyond the 40 LSB tolerance. Faults in the sequencer itself show up earlier, at the `valid` pin: a miscounted bit or iteration counter moves that rise off cycle 288, and an enable that is not masked during a run clears `valid` or restarts the run.

// File: rtl/cordic_sine_pkg.sv
package cordic_sine_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOAD = 2'd1,
        S_CLR  = 2'd2,
        S_ROT  = 2'd3
    } seq_state_e;

    // serial cell opcodes
    localparam logic [1:0] OP_HOLD = 2'b00;
    localparam logic [1:0] OP_CLR  = 2'b01;
    localparam logic [1:0] OP_SUB  = 2'b10;
    localparam logic [1:0] OP_ADD  = 2'b11;

    // coordinate lanes
    localparam int CX = 0;
    localparam int CY = 1;
    localparam int CZ = 2;

    // arctan(2^-i) in units of (pi/2)/32768
    function automatic logic [WORD_W-1:0] atan_step(input int unsigned i);
        case (i)
            0:  return 16'd16384;
            1:  return 16'd9672;
            2:  return 16'd5110;
            3:  return 16'd2594;
            4:  return 16'd1302;
            5:  return 16'd652;
            6:  return 16'd326;
            7:  return 16'd163;
            8:  return 16'd81;
            9:  return 16'd41;
            10: return 16'd20;
            11: return 16'd10;
            12: return 16'd5;
            13: return 16'd3;
            14: return 16'd1;
            15: return 16'd1;
            default: return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/cordic_bit_ram.sv
module cordic_bit_ram #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we0,
    input  logic [AW-1:0] addr0,
    input  logic          wdata0,
    output logic          rdata0,
    input  logic [AW-1:0] addr1,
    output logic          rdata1
);

    logic [DEPTH-1:0] cells_q;

    always_ff @(posedge clk) begin
        if (we0) begin
            cells_q[addr0] <= wdata0;
        end
    end

    assign rdata0 = cells_q[addr0];
    assign rdata1 = cells_q[addr1];

endmodule

// File: rtl/cordic_serial_cell.sv
module cordic_serial_cell
    import cordic_sine_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] op,
    input  logic       a,
    input  logic       b,
    output logic       sum
);

    logic cy_q, cy_d;
    logic sub, b_eff, c_in, c_out;

    always_comb begin
        sub   = (op == OP_SUB);
        b_eff = b ^ sub;
        // stored state is inverted for subtract so a cleared cell seeds carry 1
        c_in  = cy_q ^ sub;
        sum   = a ^ b_eff ^ c_in;
        c_out = (a & b_eff) | (a & c_in) | (b_eff & c_in);
        case (op)
            OP_CLR:         cy_d = 1'b0;
            OP_ADD, OP_SUB: cy_d = c_out ^ sub;
            default:        cy_d = cy_q;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cy_q <= 1'b0;
        end else begin
            cy_q <= cy_d;
        end
    end

endmodule

// File: rtl/cordic_sine_seq.sv
module cordic_sine_seq
    import cordic_sine_pkg::*;
#(
    parameter int              W      = WORD_W,
    parameter int              ITERS  = 16,
    parameter logic [W-1:0]    X_INIT = 16'd9949
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic [W-1:0] theta,
    output logic         valid,
    output logic [W-1:0] value
);

    localparam int AW = $clog2(W);
    localparam int IW = $clog2(ITERS);
    localparam int NC = 3;

    typedef struct packed {
        seq_state_e   st;
        logic [AW-1:0] bitn;
        logic [IW-1:0] iter;
        logic          neg;
        logic [W-1:0]  ang;
        logic [W-1:0]  res;
        logic          done;
    } seq_t;

    seq_t q, d;

    logic [NC-1:0]         ram_we, ram_wd, rd0, rd1, addend, sum;
    logic [NC-1:0][AW-1:0] addr1;
    logic [NC-1:0][1:0]    cell_op;
    logic [AW:0]           shift_sum;
    logic [AW-1:0]         shift_addr;
    logic [W-1:0]          atan_now;
    logic [W-1:0]          z_init;
    logic                  last_bit, last_iter;

    for (genvar c = 0; c < NC; c++) begin : g_lane
        cordic_bit_ram #(.DEPTH(W), .AW(AW)) u_ram (
            .clk   (clk),
            .we0   (ram_we[c]),
            .addr0 (q.bitn),
            .wdata0(ram_wd[c]),
            .rdata0(rd0[c]),
            .addr1 (addr1[c]),
            .rdata1(rd1[c])
        );
        cordic_serial_cell u_cell (
            .clk(clk),
            .rst(rst),
            .op (cell_op[c]),
            .a  (rd0[c]),
            .b  (addend[c]),
            .sum(sum[c])
        );
    end

    always_comb begin
        d         = q;
        shift_sum = {1'b0, q.bitn} + (AW+1)'(q.iter);
        shift_addr = (shift_sum > (AW+1)'(W-1)) ? AW'(W-1) : shift_sum[AW-1:0];
        atan_now  = atan_step(int'(q.iter));
        z_init    = {1'b0, q.ang[W-1:1]};
        last_bit  = (q.bitn == AW'(W-1));
        last_iter = (q.iter == IW'(ITERS-1));

        ram_we    = '0;
        ram_wd    = sum;
        cell_op   = '0;
        addr1[CX] = shift_addr;
        addr1[CY] = shift_addr;
        addr1[CZ] = AW'(W-1);
        addend[CX] = rd1[CY];
        addend[CY] = rd1[CX];
        addend[CZ] = atan_now[q.bitn];

        case (q.st)
            S_IDLE: begin
                if (enable) begin
                    d.ang  = theta;
                    d.st   = S_LOAD;
                    d.bitn = '0;
                    d.iter = '0;
                    d.done = 1'b0;
                end
            end
            S_LOAD: begin
                ram_we     = '1;
                ram_wd[CX] = X_INIT[q.bitn];
                ram_wd[CY] = 1'b0;
                ram_wd[CZ] = z_init[q.bitn];
                d.bitn     = q.bitn + 1'b1;
                if (last_bit) begin
                    d.st = S_CLR;
                end
            end
            S_CLR: begin
                cell_op = {NC{OP_CLR}};
                d.neg   = rd1[CZ];
                d.st    = S_ROT;
            end
            default: begin
                ram_we      = '1;
                cell_op[CX] = q.neg ? OP_ADD : OP_SUB;
                cell_op[CY] = q.neg ? OP_SUB : OP_ADD;
                cell_op[CZ] = q.neg ? OP_ADD : OP_SUB;
                if (last_iter) begin
                    d.res[q.bitn] = sum[CY];
                end
                d.bitn = q.bitn + 1'b1;
                if (last_bit) begin
                    if (last_iter) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                        d.iter = '0;
                    end else begin
                        d.iter = q.iter + 1'b1;
                        d.st   = S_CLR;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign valid = q.done;
    assign value = q.res;

endmodule

// File: rtl/cordic_sine_seq_chk.sv
module cordic_sine_seq_chk
    import cordic_sine_pkg::*;
#(
    parameter int W   = 16,
    parameter int LAT = 288
) (
    input logic            clk,
    input logic            rst,
    input logic            enable,
    input logic            valid,
    input logic [W-1:0]    value,
    input seq_state_e      st,
    input logic [2:0][1:0] op
);

    logic [15:0] since_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            since_q <= '1;
        end else if (st == S_IDLE && enable) begin
            since_q <= '0;
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_ACCEPT_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && enable) |=> !valid); // R3

    AST_LATENCY_EXACT: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> (since_q == 16'(LAT))); // R4

    AST_BUSY_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE) |-> !valid); // R5

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (valid && !enable) |=> (valid && $stable(value))); // R6

    AST_XY_OPPOSITE: assert property (@(posedge clk) disable iff (rst)
        (st == S_ROT) |-> (op[0] != op[1] && op[0][1] && op[1][1])); // R7

    AST_Z_TRACKS_X: assert property (@(posedge clk) disable iff (rst)
        (st == S_ROT) |-> (op[2] == op[0])); // R7

endmodule

bind cordic_sine_seq cordic_sine_seq_chk #(.W(W), .LAT(W + ITERS * (W + 1))) u_chk (
    .clk   (clk),
    .rst   (rst),
    .enable(enable),
    .valid (valid),
    .value (value),
    .st    (q.st),
    .op    (cell_op)
);

// File: tb/cordic_sine_seq_tb.sv
module cordic_sine_seq_tb;

    localparam int CLK_P = 10;
    localparam int LAT   = 288;
    localparam int TOL   = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [15:0] theta = '0;
    logic        valid;
    logic [15:0] value;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    cordic_sine_seq u_dut (
        .clk   (clk),
        .rst   (rst),
        .enable(enable),
        .theta (theta),
        .valid (valid),
        .value (value)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            report();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sin_ref(input int th);
        real a;
        a = real'(th) * 3.14159265358979 / 2.0 / 65536.0;
        return int'($sin(a) * 16384.0);
    endfunction

    // pulse enable for exactly one rising edge, return at the next falling edge
    task automatic launch(input int th);
        @(negedge clk);
        theta  = 16'(th);
        enable = 1'b1;
        @(negedge clk);
        enable = 1'b0;
    endtask

    task automatic wait_valid(output int lat);
        lat = 0;
        while (!valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_value(input int th, input string req);
        int act, exp, diff;
        act  = int'($signed(value));
        exp  = sin_ref(th);
        diff = act - exp;
        if (diff < 0) diff = -diff;
        check(diff <= TOL, req, act, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(valid == 1'b0, "R1 valid after reset", int'(valid), 0);
        check(value == 16'd0, "R1 value after reset", int'(value), 0);
    endtask

    // R2 accuracy, R4 latency, R7 direction choice: both signs of residual occur
    task automatic t_angle(input int th);
        int lat;
        launch(th);
        check(valid == 1'b0, "R3 valid low after accept", int'(valid), 0);
        wait_valid(lat);
        check(lat == LAT, "R4 latency", lat, LAT);
        check_value(th, "R2/R7 sine value");
    endtask

    task automatic t_busy_ignore();
        int lat;
        bit low_ok;
        launch(20000);
        low_ok = 1'b1;
        lat = 0;
        repeat (50) begin
            if (valid) low_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        theta  = 16'd60000;
        enable = 1'b1;
        @(negedge clk);
        lat++;
        enable = 1'b0;
        theta  = 16'd5;
        while (!valid && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        check(low_ok, "R5 valid low while busy", int'(low_ok), 1);
        check(lat == LAT, "R5 busy enable ignored, latency", lat, LAT);
        check_value(20000, "R5 result of accepted angle");
    endtask

    task automatic t_hold();
        logic [15:0] snap;
        bit ok;
        snap = value;
        ok = valid;
        for (int k = 0; k < 25; k++) begin
            theta = 16'(k * 2617);
            @(negedge clk);
            if (!valid || value != snap) ok = 1'b0;
        end
        check(ok, "R6 result held with enable low", int'(value), int'(snap));
    endtask

    task automatic t_accept_drop();
        int lat;
        check(valid == 1'b1, "R3 valid high before new angle", int'(valid), 1);
        launch(40000);
        check(valid == 1'b0, "R3 valid drops at accept", int'(valid), 0);
        wait_valid(lat);
        check(lat == LAT, "R4 latency back to back", lat, LAT);
        check_value(40000, "R2 value after restart");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_angle(0);
        t_angle(8192);
        t_angle(16384);
        t_angle(32768);
        t_angle(45000);
        t_angle(60000);
        t_angle(65535);
        t_angle(1234);
        t_busy_ignore();
        t_hold();
        t_accept_drop();
        report();
        $finish;
    end

endmodule